// File: doc/BRIEF.md
# Trigger Divider with Selectable Reset Alignment

This block divides a stream of trigger events by a ratio that can change at run time. Both the trigger input and the re-arm input are sampled by the system clock. A rising edge on the trigger input counts as one event. After every N events the block emits an output pulse that lasts one clock cycle. It also drives a level output that stays high for as long as the trigger that caused the pulse stays high.

A rising edge on the re-arm input clears both outputs and restarts the count. A run-time select decides where the first output falls after a re-arm:

- **Immediate alignment:** the very next trigger event fires the output. Several dividers re-armed together therefore all fire on their first shared trigger.
- **Counted alignment:** the output first fires on the Nth event, so a re-arm followed by N events gives exactly one output.

Both alignments produce the same period once running. A new ratio is taken only at a re-arm or when the count wraps, so changing it never produces a stray pulse.

Top module: `trig_divider`

## Requirements
- R1: Once running, `pulse_o` fires once for every N trigger rising edges, where N is the unsigned value on `ratio_i`.
- R2: A rising edge on `rearm_i` forces `pulse_o` and `level_o` low after the next clock edge, whatever the trigger input does.
- R3: With `align_i` = 1 (immediate), the first trigger rising edge after a re-arm fires `pulse_o`. After that, every Nth edge fires it.
- R4: With `align_i` = 0 (counted), the first pulse after a re-arm comes on the Nth trigger edge. A re-arm followed by N edges yields exactly one pulse, and a re-arm followed by N-1 edges yields none.
- R5: A trigger rising edge is a clock cycle where the sampled input is 1 and the sample from the previous cycle was 0. Holding the trigger high gives only one edge.
- R6: `ratio_i` = 0 behaves as 1. With a ratio of 1, every trigger edge produces a pulse.
- R7: If a re-arm edge and a trigger edge are sampled in the same cycle, the re-arm wins and that trigger edge is not counted.
- R8: A new `ratio_i` value is used only from the next re-arm or the next wrap of the count. `align_i` is read only at a re-arm.
- R9: `level_o` rises together with `pulse_o`. It stays high while the trigger stays high and falls one clock after the trigger is sampled low.
- R10: While `rst_n` is low, both outputs are 0 and the count is aligned as for a re-arm, using the current `align_i` and `ratio_i`.
- R11: `pulse_o` is never high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous system reset, active low |
| trig_i | input | 1 | Trigger input, sampled by clk |
| rearm_i | input | 1 | Re-arm input; a rising edge restarts the count |
| align_i | input | 1 | Re-arm alignment: 1 = immediate, 0 = counted |
| ratio_i | input | RATIO_W | Division ratio N (0 is treated as 1) |
| pulse_o | output | 1 | One-cycle output pulse every N trigger edges |
| level_o | output | 1 | Output level that follows the trigger high time of a firing edge |

## Verification
The bound checker checks the following on every cycle:

- a pulse never lasts two cycles;
- a pulse is always preceded by a sampled trigger rising edge;
- the level output is high only while the trigger was sampled high;
- a re-arm edge clears both outputs;
- the internal count stays below the latched ratio, and the latched ratio is never zero.

Properties that depend on how many edges have been counted need the bench's scenarios and its cycle-accurate reference model. These include:

- the Nth-edge placement of the first pulse under counted alignment;
- the first-edge pulse under immediate alignment;
- deferral of a ratio change until the wrap;
- the loss of a trigger edge that collides with a re-arm.

// File: rtl/trigdiv_pkg.sv
package trigdiv_pkg;

   typedef enum logic {
      ALIGN_COUNTED   = 1'b0,
      ALIGN_IMMEDIATE = 1'b1
   } align_e;

endpackage

// File: rtl/tdv_edge.sv
module tdv_edge #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   output logic rise_o,
   output logic samp_o
);

   initial begin
      if (STAGES < 0 || STAGES > 3)
         $error("tdv_edge: STAGES must be 0..3");
   end

   logic samp;
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_direct
         assign samp = sig_i;
      end else begin : g_sync
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], sig_i};
         end
         assign samp = chain_q[STAGES-1];
      end
   endgenerate

   // The previous sample keeps tracking during reset, so an input held
   // high across reset release is not seen as an edge.
   always_ff @(posedge clk) begin
      prev_q <= samp;
   end

   assign rise_o = samp & ~prev_q;
   assign samp_o = samp;

endmodule

// File: rtl/tdv_count.sv
module tdv_count
   import trigdiv_pkg::*;
#(
   parameter int RATIO_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [RATIO_W-1:0] ratio_i,
   input  logic               align_i,
   input  logic               rearm_i,
   input  logic               step_i,
   output logic               fire_o,
   output logic [RATIO_W-1:0] count_o,
   output logic [RATIO_W-1:0] limit_o
);

   localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

   logic [RATIO_W-1:0] count_q;
   logic [RATIO_W-1:0] limit_q;
   logic [RATIO_W-1:0] ratio_ok;
   logic               at_end;
   logic               align_now;

   assign ratio_ok  = (ratio_i == '0) ? ONE : ratio_i;
   assign at_end    = (count_q == limit_q - ONE);
   assign align_now = !rst_n || rearm_i;
   assign fire_o    = step_i && !align_now && at_end;

   always_ff @(posedge clk) begin
      if (align_now) begin
         limit_q <= ratio_ok;
         count_q <= (align_e'(align_i) == ALIGN_IMMEDIATE) ? ratio_ok - ONE : '0;
      end else if (step_i) begin
         if (at_end) begin
            count_q <= '0;
            limit_q <= ratio_ok;
         end else begin
            count_q <= count_q + ONE;
         end
      end
   end

   assign count_o = count_q;
   assign limit_o = limit_q;

endmodule

// File: rtl/tdv_out.sv
module tdv_out (
   input  logic clk,
   input  logic rst_n,
   input  logic fire_i,
   input  logic clear_i,
   input  logic trig_lvl_i,
   output logic pulse_o,
   output logic level_o
);

   logic pulse_q;
   logic level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= 1'b0;
         level_q <= 1'b0;
      end else begin
         pulse_q <= fire_i;
         if (clear_i)     level_q <= 1'b0;
         else if (fire_i) level_q <= 1'b1;
         else             level_q <= level_q & trig_lvl_i;
      end
   end

   assign pulse_o = pulse_q;
   assign level_o = level_q;

endmodule

// File: rtl/trig_divider.sv
module trig_divider #(
   parameter int RATIO_W   = 8,
   parameter int IN_STAGES = 0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               trig_i,
   input  logic               rearm_i,
   input  logic               align_i,
   input  logic [RATIO_W-1:0] ratio_i,
   output logic               pulse_o,
   output logic               level_o
);

   initial begin
      if (RATIO_W < 2 || RATIO_W > 16)
         $error("trig_divider: RATIO_W must be 2..16");
   end

   logic               trig_rise;
   logic               trig_samp;
   logic               rearm_rise;
   logic               rearm_samp;
   logic               fire;
   logic [RATIO_W-1:0] count_q;
   logic [RATIO_W-1:0] limit_q;

   tdv_edge #(.STAGES(IN_STAGES)) u_trig_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (trig_i),
      .rise_o (trig_rise),
      .samp_o (trig_samp)
   );

   tdv_edge #(.STAGES(IN_STAGES)) u_rearm_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .sig_i  (rearm_i),
      .rise_o (rearm_rise),
      .samp_o (rearm_samp)
   );

   tdv_count #(.RATIO_W(RATIO_W)) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .ratio_i (ratio_i),
      .align_i (align_i),
      .rearm_i (rearm_rise),
      .step_i  (trig_rise),
      .fire_o  (fire),
      .count_o (count_q),
      .limit_o (limit_q)
   );

   tdv_out u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .fire_i     (fire),
      .clear_i    (rearm_rise),
      .trig_lvl_i (trig_samp),
      .pulse_o    (pulse_o),
      .level_o    (level_o)
   );

endmodule

// File: rtl/tdv_check.sv
module tdv_check #(
   parameter int RATIO_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               trig_samp,
   input logic               rearm_samp,
   input logic               pulse_o,
   input logic               level_o,
   input logic [RATIO_W-1:0] count_q,
   input logic [RATIO_W-1:0] limit_q
);

   logic t1, t2, r1;

   always_ff @(posedge clk) begin
      t1 <= trig_samp;
      t2 <= t1;
      r1 <= rearm_samp;
   end

   assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);

   assert_rearm_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rearm_samp && !r1) |=> (!pulse_o && !level_o));

   assert_pulse_after_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |-> (t1 && !t2));

   assert_level_follows_trig_R9: assert property (@(posedge clk) disable iff (!rst_n)
      level_o |-> t1);

   assert_count_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count_q < limit_q);

   assert_limit_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      limit_q != '0);

endmodule

bind trig_divider tdv_check #(.RATIO_W(RATIO_W)) u_check (
   .clk        (clk),
   .rst_n      (rst_n),
   .trig_samp  (trig_samp),
   .rearm_samp (rearm_samp),
   .pulse_o    (pulse_o),
   .level_o    (level_o),
   .count_q    (count_q),
   .limit_q    (limit_q)
);

// File: tb/sim_trig_divider.sv
module sim_trig_divider;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       trig;
   logic       rearm;
   logic       align;
   logic [7:0] ratio;
   logic       pulse;
   logic       level;

   int checks = 0;
   int fails  = 0;
   int pcnt   = 0;
   int lcnt   = 0;
   bit started = 0;

   // reference model state
   int m_left, m_n;
   bit m_pulse, m_level, m_pt, m_pr;

   always #5 clk = ~clk;

   trig_divider u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_i  (trig),
      .rearm_i (rearm),
      .align_i (align),
      .ratio_i (ratio),
      .pulse_o (pulse),
      .level_o (level)
   );

   function automatic int eff(input logic [7:0] r);
      return (r == 0) ? 1 : int'(r);
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural model: events remaining before the next output.
   always @(posedge clk) begin
      bit te, re, fire;
      started = 1;
      if (!rst_n) begin
         m_pulse = 0; m_level = 0;
         m_n = eff(ratio);
         m_left = align ? 1 : m_n;
      end else begin
         te = trig && !m_pt;
         re = rearm && !m_pr;
         fire = 0;
         if (re) begin
            m_n = eff(ratio);
            m_left = align ? 1 : m_n;
            m_level = 0;
         end else begin
            if (te) begin
               m_left = m_left - 1;
               if (m_left == 0) begin
                  fire = 1;
                  m_n = eff(ratio);
                  m_left = m_n;
               end
            end
            m_level = fire ? 1'b1 : (m_level && trig);
         end
         m_pulse = fire;
      end
      m_pt = trig;
      m_pr = rearm;
   end

   always @(negedge clk) begin
      if (started) begin
         check("R1 model pulse", int'(pulse), int'(m_pulse));
         check("R9 model level", int'(level), int'(m_level));
         if (rst_n) begin
            if (pulse === 1'b1) pcnt++;
            if (level === 1'b1) lcnt++;
         end
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic tedge();
      trig = 1; cyc(2);
      trig = 0; cyc(2);
   endtask

   task automatic edges(input int n);
      for (int i = 0; i < n; i++) tedge();
   endtask

   task automatic rearm_now();
      rearm = 1; cyc(1);
      rearm = 0; cyc(2);
      pcnt = 0; lcnt = 0;
   endtask

   initial begin
      #1500000;
      fails++; checks++;
      $display("FAIL watchdog: actual 0 expected 1 (run finished)");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 0; trig = 0; rearm = 0; align = 0; ratio = 8'd4;
      cyc(3);
      check("R10 reset pulse", int'(pulse), 0);
      check("R10 reset level", int'(level), 0);
      rst_n = 1; cyc(1);

      // R4 counted alignment, N=4
      align = 0; ratio = 4; rearm_now();
      edges(3);
      check("R4 counted no pulse after N-1", pcnt, 0);
      edges(1);
      check("R4 counted one pulse after N", pcnt, 1);
      edges(8);
      check("R1 steady division by 4", pcnt, 3);

      // R3 immediate alignment
      align = 1; rearm_now();
      edges(1);
      check("R3 immediate first edge fires", pcnt, 1);
      edges(4);
      check("R3 immediate then every Nth", pcnt, 2);

      // R6 ratio 0 and 1
      ratio = 0; align = 0; rearm_now();
      edges(3);
      check("R6 ratio 0 acts as 1", pcnt, 3);
      ratio = 1; rearm_now();
      edges(2);
      check("R6 ratio 1 every edge", pcnt, 2);

      // R7 collision: re-arm wins
      ratio = 2; align = 0; rearm_now();
      rearm = 1; trig = 1; cyc(2);
      rearm = 0; trig = 0; cyc(2);
      pcnt = 0;
      edges(1);
      check("R7 colliding edge not counted", pcnt, 0);
      edges(1);
      check("R7 count resumes after collision", pcnt, 1);

      // R8 ratio change deferred until wrap
      ratio = 3; align = 0; rearm_now();
      edges(1);
      ratio = 5;
      edges(2);
      check("R8 old ratio holds until wrap", pcnt, 1);
      edges(4);
      check("R8 new ratio not yet wrapped", pcnt, 1);
      edges(1);
      check("R8 new ratio after wrap", pcnt, 2);
      align = 1; edges(5);
      check("R8 align change ignored until re-arm", pcnt, 3);

      // R9 / R11 level width and single pulse
      ratio = 1; align = 0; rearm_now();
      trig = 1; cyc(5);
      trig = 0; cyc(3);
      check("R9 level high for trigger high time", lcnt, 5);
      check("R11 single-cycle pulse", pcnt, 1);

      // R5 trigger held high gives one edge
      rearm_now();
      trig = 1; cyc(10);
      check("R5 held trigger counts once", pcnt, 1);

      // R2 re-arm while output level high
      rearm = 1; cyc(1);
      check("R2 re-arm clears level", int'(level), 0);
      check("R2 re-arm clears pulse", int'(pulse), 0);
      rearm = 0; trig = 0; cyc(2);

      // R10 system reset aligns like a re-arm
      align = 1; ratio = 3; rst_n = 0; cyc(2);
      rst_n = 1; cyc(1);
      pcnt = 0;
      edges(1);
      check("R10 reset uses immediate alignment", pcnt, 1);
      edges(3);
      check("R10 then division by 3", pcnt, 2);

      cyc(2);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule